// File: doc/BRIEF.md
# Sub-word Register Access Adapter

This block sits between a byte-addressable I/O window of 128 bytes and a set of internal registers that only take whole 32-bit accesses. Each incoming request carries a byte offset, a size code and a direction. The adapter decodes the offset into one of three register regions and an index within it. Core registers occupy the lower half of the window, DMA registers the next 32 bytes, and a single bus-control register sits near the top. The adapter then forwards exactly one aligned 32-bit access downstream.

A byte or halfword write, or any unaligned write, becomes a full-word write. The adapter fetches the target register's current contents through a side-effect-free peek port in the request cycle. It replaces only the lanes the request covers and leaves the other lanes at their current value. On a read, the adapter shifts the returned word down by the byte offset and masks it to the access size. Offsets that decode to no register return zero on a read, and writes to them are dropped.

The peek port is combinational. The access port is registered one cycle after the request. The response comes one cycle after that.

Top module: `subword_adapter`

## Requirements
- R1: A read at any offset 0x00-0x3F, and a write whose word-aligned offset lies in 0x00-0x3F, strobe region code 1 (core) with index offset>>2.
- R2: Offsets 0x40-0x5F strobe region code 2 (DMA) with index (offset-0x40)>>2, under the same read and write rules as R1.
- R3: A write at any offset 0x70-0x73 strobes region code 3 (control) with index 0. A read reaches the control register only at exactly offset 0x70.
- R4: No access strobe is issued for writes at 0x60-0x6F or 0x74-0x7F, nor for reads at offsets 0x60-0x7F other than 0x70. Such reads respond with data 0.
- R5: Size code 0 means 1 byte, 1 means 2 bytes, and 2 or 3 mean 4 bytes. In a narrow or unaligned write, byte k of wdata_i goes to lane (offset[1:0]+k) of the written word, and bytes that fall past lane 3 are dropped. Every other lane takes the value of pk_data_i from the request cycle.
- R6: An aligned 4-byte write forwards wdata_i unchanged, whatever pk_data_i holds.
- R7: In the request cycle, pk_rgn_o/pk_idx_o follow the offset combinationally. They name the core and DMA registers as in R1/R2, region 3 index 0 for 0x60-0x73, and region 0 index 0 for 0x74-0x7F.
- R8: Read response data is acc_rdata_i shifted right by 8*offset[1:0] and masked to 8*size bits. Lanes above the access size read as 0.
- R9: The access port outputs appear one cycle after a request, with exactly one strobe per decoded request. rsp_valid_o follows one cycle later for every request, and rsp_rdata_o is 0 for writes.
- R10: While rst_ni is low, acc_stb_o and rsp_valid_o are 0 and rsp_rdata_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request valid for one cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 7 | Byte offset in the window |
| size_i | input | 2 | Size code (0:1 B, 1:2 B, 2/3:4 B) |
| wdata_i | input | 32 | Write data, right-aligned |
| rsp_valid_o | output | 1 | Response valid |
| rsp_rdata_o | output | 32 | Read data, right-aligned and masked |
| pk_rgn_o | output | 2 | Peek region (0 none, 1 core, 2 DMA, 3 control) |
| pk_idx_o | output | 4 | Peek register index |
| pk_data_i | input | 32 | Current value of the peeked register, no side effects |
| acc_stb_o | output | 1 | Downstream access strobe |
| acc_we_o | output | 1 | Downstream access is a write |
| acc_rgn_o | output | 2 | Downstream region |
| acc_idx_o | output | 4 | Downstream register index |
| acc_wdata_o | output | 32 | Full-word write data after merge |
| acc_rdata_i | input | 32 | Downstream read data, valid while acc_stb_o is high |

## Verification
A wrong lane offset or size decode in the merge corrupts a neighbouring byte of a register. It shows in the same cycle the strobe rises, as a mismatch between acc_wdata_o and the lanes kept from the peek value. A read-back of the whole word then exposes it one access later. A wrong region or index decode shows on acc_rgn_o/acc_idx_o one cycle after the request, or on pk_rgn_o in the request cycle itself. A misplaced shift or mask appears on rsp_rdata_o two cycles after the request. The sweep covers every offset of the window against every size code, so each offset-dependent branch is reached.

// File: rtl/adp_pkg.sv
package adp_pkg;
  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_CORE = 2'd1,
    RGN_DMA  = 2'd2,
    RGN_CTRL = 2'd3
  } rgn_e;
endpackage

// File: rtl/adp_decode.sv
module adp_decode
  import adp_pkg::*;
#(
  parameter int AW        = 7,
  parameter int IW        = 4,
  parameter int LW        = 2,
  parameter int CORE_END  = 64,
  parameter int DMA_END   = 96,
  parameter int CTRL_OFF  = 112,
  parameter int CTRL_END  = 116,
  parameter bit WIDE_CTRL = 1'b0
) (
  input  logic [AW-1:0] addr_i,
  output logic [1:0]    rgn_o,
  output logic [IW-1:0] idx_o
);
  localparam logic [AW-1:0] CORE_A = AW'(CORE_END);
  localparam logic [AW-1:0] DMA_A  = AW'(DMA_END);
  localparam logic [AW-1:0] CTRL_A = AW'(CTRL_OFF);
  localparam logic [AW-1:0] CTRL_E = AW'(CTRL_END);

  logic          ctrl_hit;
  logic [AW-1:0] off;

  // peek path spans the whole upper gap; access path matches one offset
  if (WIDE_CTRL) begin : g_wide
    assign ctrl_hit = (addr_i >= DMA_A) && (addr_i < CTRL_E);
  end else begin : g_exact
    assign ctrl_hit = (addr_i == CTRL_A);
  end

  always_comb begin
    rgn_o = RGN_NONE;
    off   = '0;
    if (addr_i < CORE_A) begin
      rgn_o = RGN_CORE;
      off   = addr_i;
    end else if (addr_i < DMA_A) begin
      rgn_o = RGN_DMA;
      off   = addr_i - CORE_A;
    end else if (ctrl_hit) begin
      rgn_o = RGN_CTRL;
    end
  end

  assign idx_o = IW'(off >> LW);
endmodule

// File: rtl/adp_merge.sv
module adp_merge #(
  parameter int DW = 32,
  parameter int LW = 2
) (
  input  logic [DW-1:0] cur_i,
  input  logic [DW-1:0] new_i,
  input  logic [LW-1:0] ofs_i,
  input  logic [1:0]    size_i,
  output logic [DW-1:0] out_o
);
  localparam int NB = DW / 8;

  int nb;

  always_comb begin
    nb = 1 << size_i;
    if (nb > NB) nb = NB;
    for (int j = 0; j < NB; j++) begin
      out_o[8*j +: 8] = cur_i[8*j +: 8];
      for (int k = 0; k < NB; k++) begin
        if ((k < nb) && (k + int'(ofs_i) == j)) out_o[8*j +: 8] = new_i[8*k +: 8];
      end
    end
  end
endmodule

// File: rtl/adp_align.sv
module adp_align #(
  parameter int DW = 32,
  parameter int LW = 2
) (
  input  logic [DW-1:0] data_i,
  input  logic [LW-1:0] ofs_i,
  input  logic [1:0]    size_i,
  output logic [DW-1:0] out_o
);
  localparam int NB = DW / 8;

  logic [DW-1:0] shifted;
  int            nb;

  always_comb begin
    nb = 1 << size_i;
    if (nb > NB) nb = NB;
    shifted = data_i >> (8 * int'(ofs_i));
    for (int j = 0; j < NB; j++) begin
      out_o[8*j +: 8] = (j < nb) ? shifted[8*j +: 8] : 8'h00;
    end
  end
endmodule

// File: rtl/subword_adapter.sv
module subword_adapter
  import adp_pkg::*;
#(
  parameter int DW       = 32,
  parameter int AW       = 7,
  parameter int CORE_END = 64,
  parameter int DMA_END  = 96,
  parameter int CTRL_OFF = 112,
  parameter int CTRL_END = 116,
  parameter int IW       = $clog2(CORE_END / (DW / 8))
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  input  logic [DW-1:0] wdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic [1:0]    pk_rgn_o,
  output logic [IW-1:0] pk_idx_o,
  input  logic [DW-1:0] pk_data_i,
  output logic          acc_stb_o,
  output logic          acc_we_o,
  output logic [1:0]    acc_rgn_o,
  output logic [IW-1:0] acc_idx_o,
  output logic [DW-1:0] acc_wdata_o,
  input  logic [DW-1:0] acc_rdata_i
);
  localparam int NB = DW / 8;
  localparam int LW = $clog2(NB);

  logic [AW-1:0] addr_al;
  logic [1:0]    wr_rgn, rd_rgn, sel_rgn;
  logic [IW-1:0] wr_idx, rd_idx, sel_idx;
  logic [DW-1:0] merged, aligned;

  assign addr_al = {addr_i[AW-1:LW], LW'(0)};

  adp_decode #(.AW(AW), .IW(IW), .LW(LW), .CORE_END(CORE_END), .DMA_END(DMA_END),
               .CTRL_OFF(CTRL_OFF), .CTRL_END(CTRL_END), .WIDE_CTRL(1'b0))
    u_dec_wr (.addr_i(addr_al), .rgn_o(wr_rgn), .idx_o(wr_idx));

  adp_decode #(.AW(AW), .IW(IW), .LW(LW), .CORE_END(CORE_END), .DMA_END(DMA_END),
               .CTRL_OFF(CTRL_OFF), .CTRL_END(CTRL_END), .WIDE_CTRL(1'b0))
    u_dec_rd (.addr_i(addr_i), .rgn_o(rd_rgn), .idx_o(rd_idx));

  adp_decode #(.AW(AW), .IW(IW), .LW(LW), .CORE_END(CORE_END), .DMA_END(DMA_END),
               .CTRL_OFF(CTRL_OFF), .CTRL_END(CTRL_END), .WIDE_CTRL(1'b1))
    u_dec_pk (.addr_i(addr_i), .rgn_o(pk_rgn_o), .idx_o(pk_idx_o));

  adp_merge #(.DW(DW), .LW(LW)) u_merge (
    .cur_i(pk_data_i), .new_i(wdata_i), .ofs_i(addr_i[LW-1:0]),
    .size_i(size_i), .out_o(merged)
  );

  assign sel_rgn = we_i ? wr_rgn : rd_rgn;
  assign sel_idx = we_i ? wr_idx : rd_idx;

  // stage 1: single downstream access
  logic          acc_stb_q, acc_we_q, pend_q;
  logic [1:0]    acc_rgn_q;
  logic [IW-1:0] acc_idx_q;
  logic [DW-1:0] acc_wdata_q;
  logic [LW-1:0] ofs_q;
  logic [1:0]    size_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_stb_q   <= 1'b0;
      acc_we_q    <= 1'b0;
      pend_q      <= 1'b0;
      acc_rgn_q   <= RGN_NONE;
      acc_idx_q   <= '0;
      acc_wdata_q <= '0;
      ofs_q       <= '0;
      size_q      <= '0;
    end else begin
      acc_stb_q <= req_i && (sel_rgn != RGN_NONE);
      pend_q    <= req_i;
      if (req_i) begin
        acc_we_q    <= we_i;
        acc_rgn_q   <= sel_rgn;
        acc_idx_q   <= sel_idx;
        acc_wdata_q <= we_i ? merged : '0;
        ofs_q       <= addr_i[LW-1:0];
        size_q      <= size_i;
      end
    end
  end

  assign acc_stb_o   = acc_stb_q;
  assign acc_we_o    = acc_we_q;
  assign acc_rgn_o   = acc_rgn_q;
  assign acc_idx_o   = acc_idx_q;
  assign acc_wdata_o = acc_wdata_q;

  adp_align #(.DW(DW), .LW(LW)) u_align (
    .data_i(acc_rdata_i), .ofs_i(ofs_q), .size_i(size_q), .out_o(aligned)
  );

  // stage 2: response
  logic          rsp_valid_q;
  logic [DW-1:0] rsp_rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= pend_q;
      rsp_rdata_q <= (acc_stb_q && !acc_we_q) ? aligned : '0;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;

  AST_STB_FROM_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_stb_o |-> $past(req_i)); // R9
  AST_RSP_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(req_i, 2)); // R9
  AST_NO_DEAD_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_stb_o |-> (acc_rgn_o != RGN_NONE)); // R4
  AST_CTRL_IDX_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_stb_o && acc_rgn_o == RGN_CTRL) |-> (acc_idx_o == '0)); // R3
  AST_WIDE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && size_i[1] && addr_i[LW-1:0] == '0) |=> (acc_wdata_o == $past(wdata_i))); // R6
  AST_BYTE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && size_i == 2'd0 && addr_i[LW-1:0] == '0)
      |=> (acc_wdata_o[DW-1:8] == $past(pk_data_i[DW-1:8]))); // R5
  AST_RD_BYTE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && $past(size_i, 2) == 2'd0) |-> (rsp_rdata_o[DW-1:8] == '0)); // R8
endmodule

// File: tb/subword_adapter_tb_top.sv
module subword_adapter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [6:0]  addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [1:0]  pk_rgn;
  logic [3:0]  pk_idx;
  logic [31:0] pk_data;
  logic        acc_stb, acc_we;
  logic [1:0]  acc_rgn;
  logic [3:0]  acc_idx;
  logic [31:0] acc_wdata, acc_rdata;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  subword_adapter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .pk_rgn_o(pk_rgn), .pk_idx_o(pk_idx), .pk_data_i(pk_data),
    .acc_stb_o(acc_stb), .acc_we_o(acc_we), .acc_rgn_o(acc_rgn), .acc_idx_o(acc_idx),
    .acc_wdata_o(acc_wdata), .acc_rdata_i(acc_rdata)
  );

  // downstream register model
  logic [31:0] core_m [16];
  logic [31:0] dma_m  [8];
  logic [31:0] ctrl_m;

  function automatic logic [31:0] mget(input int rgn, input int idx);
    case (rgn)
      1: return core_m[idx];
      2: return dma_m[idx % 8];
      3: return ctrl_m;
      default: return 32'h0;
    endcase
  endfunction

  always_comb pk_data = mget(int'(pk_rgn), int'(pk_idx));
  always_comb acc_rdata = acc_stb ? mget(int'(acc_rgn), int'(acc_idx)) : 32'hDEAD_BEEF;

  always @(posedge clk) begin
    if (rst_n && acc_stb && acc_we) begin
      case (acc_rgn)
        2'd1: core_m[acc_idx] = acc_wdata;
        2'd2: dma_m[acc_idx[2:0]] = acc_wdata;
        2'd3: ctrl_m = acc_wdata;
        default: ;
      endcase
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int rd_rgn(input int a);
    if (a < 64) return 1;
    if (a < 96) return 2;
    if (a == 112) return 3;
    return 0;
  endfunction

  function automatic int pk_rgn_f(input int a);
    if (a < 64) return 1;
    if (a < 96) return 2;
    if (a < 116) return 3;
    return 0;
  endfunction

  function automatic int idx_f(input int rgn, input int a);
    if (rgn == 1) return a / 4;
    if (rgn == 2) return (a - 64) / 4;
    return 0;
  endfunction

  function automatic int nbytes(input int sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  function automatic string rtag(input int rgn);
    return (rgn == 1) ? "R1" : (rgn == 2) ? "R2" : (rgn == 3) ? "R3" : "R4";
  endfunction

  task automatic do_acc(input bit w, input int a, input int sz, input logic [31:0] d);
    int er, ei, pr, pi, ofs, nb;
    logic [31:0] cur, exp_w, exp_r, tgt;
    ofs = a % 4;
    nb  = nbytes(sz);
    er  = w ? rd_rgn(a - ofs) : rd_rgn(a);
    if (w && (a - ofs) == 112) er = 3;
    ei  = idx_f(er, w ? a - ofs : a);
    pr  = pk_rgn_f(a);
    pi  = idx_f(pr, a);
    cur = mget(pr, pi);
    exp_w = cur;
    for (int k = 0; k < nb; k++)
      if (ofs + k < 4) exp_w[8*(ofs+k) +: 8] = d[8*k +: 8];
    tgt = mget(er, ei);
    exp_r = tgt >> (8 * ofs);
    if (nb < 4) exp_r = exp_r & ((32'h1 << (8 * nb)) - 32'h1);
    if (er == 0) exp_r = 32'h0;

    @(negedge clk);
    req = 1'b1; we = w; addr = 7'(a); size = 2'(sz); wdata = d;
    #1;
    chk("R7", "peek region", 32'(pk_rgn), 32'(pr));
    chk("R7", "peek index", 32'(pk_idx), 32'(pi));
    @(negedge clk);
    req = 1'b0;
    chk((er == 0) ? "R4" : "R9", "strobe", 32'(acc_stb), 32'(er != 0));
    if (er != 0) begin
      chk(rtag(er), "acc region", 32'(acc_rgn), 32'(er));
      chk(rtag(er), "acc index", 32'(acc_idx), 32'(ei));
      chk("R9", "acc we", 32'(acc_we), 32'(w));
      if (w) chk((sz >= 2 && ofs == 0) ? "R6" : "R5", "merged wdata", acc_wdata, exp_w);
    end
    @(negedge clk);
    chk("R9", "rsp valid", 32'(rsp_valid), 32'h1);
    chk("R9", "single strobe", 32'(acc_stb), 32'h0);
    if (w) chk("R9", "write rsp data", rsp_rdata, 32'h0);
    else   chk((er == 0) ? "R4" : "R8", "read data", rsp_rdata, exp_r);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) core_m[i] = 32'h1122_3344 ^ (32'(i) * 32'h0101_0101);
    for (int i = 0; i < 8; i++)  dma_m[i]  = 32'h8899_AABB ^ (32'(i) * 32'h0202_0202);
    ctrl_m = 32'hCAFE_F00D;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", "reset strobe", 32'(acc_stb), 32'h0);
    chk("R10", "reset rsp valid", 32'(rsp_valid), 32'h0);
    chk("R10", "reset rsp data", rsp_rdata, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int a = 0; a < 128; a++) begin
      for (int sz = 0; sz < 4; sz++) begin
        do_acc(1'b1, a, sz, 32'hC3A5_0F00 ^ (32'(a) * 32'h0103_0507) ^ (32'(sz) << 28));
        do_acc(1'b0, a, sz, 32'h0);
        do_acc(1'b0, a - (a % 4), 2, 32'h0);
      end
    end
    // aligned full write ignores peek value
    do_acc(1'b1, 8'h44, 2, 32'h0BAD_CAFE);
    do_acc(1'b0, 8'h44, 2, 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule